// File: doc/BRIEF.md
# DMA Channel Run-State Controller

This block decides, for a single DMA channel, whether the channel is idle, moving data or parked between descriptors. Software sets an enable bit, a continue bit and a continue-from-start bit in control registers; a write strobe to those registers makes the controller look at them. The data path reports each finished descriptor with a one-cycle pulse carrying the descriptor's 2-bit command field, and reports descriptor fetch failures on a separate input.

In return the controller publishes a 2-bit status code and issues one-cycle pulses: a run strobe that starts the data path, a request to clear the enable bit, a request to clear the continue bit, a pointer-reload request qualified by a bit that picks the start addresses or the next descriptor, a completion event and a pause event. Address arithmetic, data movement and interrupt storage live elsewhere and act on these pulses.

Top module: `dma_run_ctl`

## Requirements
- R1: During and right after reset the status is 0 and every pulse output is low.
- R2: The status reads 0 when disabled, 1 when enabled, 2 when paused, and 3 whenever the error flag is set regardless of state. All outputs are registered and change one clock after the edge that samples the causing inputs.
- R3: In register mode (mem_mode_i=0) a completion while enabled always disables the channel and pulses clr_en_o, whatever the command.
- R4: In memory mode a completion with command 2 disables the channel and pulses clr_en_o.
- R5: In memory mode a completion with command 1 moves the channel to paused and pulses pause_evt_o.
- R6: In memory mode a completion with command 0 or 3 keeps the channel enabled and pulses reload_o with reload_start_o=0 (step to next descriptor).
- R7: Every completion accepted while enabled pulses done_evt_o, whatever its command.
- R8: A control write with enable=1 clears the error flag; from disabled it enters enabled and pulses run_o and reload_o with reload_start_o=1.
- R9: A control write with enable=1 and continue=1 while paused enters enabled, pulses run_o, clr_cont_o and reload_o, with reload_start_o equal to the continue-from-start bit.
- R10: A control write with enable=0 and continue=1 while paused returns to disabled with no reload or run pulse.
- R11: A fetch error while enabled disables the channel with the error flag set (status 3), suppresses done_evt_o for that cycle, and the flag survives control writes with enable=0.
- R12: Control bits are decoded only on ctl_wr_i; completions and fetch errors are ignored unless the channel is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr_i | input | 1 | Write strobe to either control register |
| en_i | input | 1 | Enable bit |
| cont_i | input | 1 | Continue bit |
| cont_from_start_i | input | 1 | On resume, restart from the start addresses |
| mem_mode_i | input | 1 | 1: descriptors in memory, 0: register mode |
| dsc_done_i | input | 1 | Descriptor completed pulse |
| dsc_cmd_i | input | 2 | Command field of the completed descriptor |
| fetch_err_i | input | 1 | Descriptor fetch error |
| status_o | output | 2 | Run status code |
| run_o | output | 1 | Start strobe to the data path |
| clr_en_o | output | 1 | Request to clear the enable bit |
| clr_cont_o | output | 1 | Request to clear the continue bit |
| reload_o | output | 1 | Pointer reload request |
| reload_start_o | output | 1 | With reload_o: 1 = start addresses, 0 = next descriptor |
| done_evt_o | output | 1 | Descriptor completion event |
| pause_evt_o | output | 1 | Pause event |

## Verification
Completions are driven in both pointer modes with all four command values, so the bench separates the register-mode "always end" rule from the memory-mode decode of stop, halt and step. Resume writes are tried with continue-from-start both set and clear, and an abandoning write with enable low, which distinguishes the three exits from paused. Control-bit changes without a strobe, completions while paused and a fetch error coinciding with a completion show that inputs outside their window change nothing. A behavioural model tracks the expected outputs on every clock alongside the directed checks.

// File: rtl/dma_run_pkg.sv
package dma_run_pkg;

    localparam int CMD_W = 2;

    typedef enum logic [1:0] {
        RS_OFF  = 2'd0,
        RS_RUN  = 2'd1,
        RS_HOLD = 2'd2
    } run_state_e;

    localparam logic [1:0] STATUS_FAULT = 2'd3;

    localparam logic [CMD_W-1:0] DCMD_PAUSE = CMD_W'(1);
    localparam logic [CMD_W-1:0] DCMD_END   = CMD_W'(2);

    typedef enum logic [1:0] {
        OUT_NEXT  = 2'd0,
        OUT_END   = 2'd1,
        OUT_PAUSE = 2'd2
    } dsc_outcome_e;

    typedef enum logic [1:0] {
        ACT_NONE    = 2'd0,
        ACT_START   = 2'd1,
        ACT_RESUME  = 2'd2,
        ACT_ABANDON = 2'd3
    } ctl_action_e;

    typedef struct packed {
        run_state_e st;
        logic       fault;
        logic       run;
        logic       clr_en;
        logic       clr_cont;
        logic       reload;
        logic       reload_start;
        logic       done_evt;
        logic       pause_evt;
    } run_regs_t;

endpackage

// File: rtl/dma_run_cmd_dec.sv
module dma_run_cmd_dec
    import dma_run_pkg::*;
(
    input  logic             mem_mode_i,
    input  logic [CMD_W-1:0] cmd_i,
    output dsc_outcome_e     outcome_o
);
    always_comb begin
        if (!mem_mode_i) begin
            outcome_o = OUT_END;
        end else if (cmd_i == DCMD_END) begin
            outcome_o = OUT_END;
        end else if (cmd_i == DCMD_PAUSE) begin
            outcome_o = OUT_PAUSE;
        end else begin
            outcome_o = OUT_NEXT;
        end
    end
endmodule

// File: rtl/dma_run_ctl_dec.sv
module dma_run_ctl_dec
    import dma_run_pkg::*;
(
    input  run_state_e  st_i,
    input  logic        en_i,
    input  logic        cont_i,
    output ctl_action_e act_o
);
    always_comb begin
        act_o = ACT_NONE;
        case (st_i)
            RS_OFF:  if (en_i) act_o = ACT_START;
            RS_HOLD: if (cont_i) act_o = en_i ? ACT_RESUME : ACT_ABANDON;
            default: act_o = ACT_NONE;
        endcase
    end
endmodule

// File: rtl/dma_run_ctl.sv
module dma_run_ctl
    import dma_run_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr_i,
    input  logic             en_i,
    input  logic             cont_i,
    input  logic             cont_from_start_i,
    input  logic             mem_mode_i,
    input  logic             dsc_done_i,
    input  logic [CMD_W-1:0] dsc_cmd_i,
    input  logic             fetch_err_i,
    output logic [1:0]       status_o,
    output logic             run_o,
    output logic             clr_en_o,
    output logic             clr_cont_o,
    output logic             reload_o,
    output logic             reload_start_o,
    output logic             done_evt_o,
    output logic             pause_evt_o
);
    run_regs_t    regs_d, regs_q;
    dsc_outcome_e outcome;
    ctl_action_e  action;

    dma_run_cmd_dec u_cmd_dec (
        .mem_mode_i (mem_mode_i),
        .cmd_i      (dsc_cmd_i),
        .outcome_o  (outcome)
    );

    dma_run_ctl_dec u_ctl_dec (
        .st_i   (regs_q.st),
        .en_i   (en_i),
        .cont_i (cont_i),
        .act_o  (action)
    );

    always_comb begin
        regs_d              = regs_q;
        regs_d.run          = 1'b0;
        regs_d.clr_en       = 1'b0;
        regs_d.clr_cont     = 1'b0;
        regs_d.reload       = 1'b0;
        regs_d.reload_start = 1'b0;
        regs_d.done_evt     = 1'b0;
        regs_d.pause_evt    = 1'b0;
        if (regs_q.st == RS_RUN) begin
            if (fetch_err_i) begin
                regs_d.st    = RS_OFF;
                regs_d.fault = 1'b1;
            end else if (dsc_done_i) begin
                regs_d.done_evt = 1'b1;
                case (outcome)
                    OUT_END: begin
                        regs_d.st     = RS_OFF;
                        regs_d.clr_en = 1'b1;
                    end
                    OUT_PAUSE: begin
                        regs_d.st        = RS_HOLD;
                        regs_d.pause_evt = 1'b1;
                    end
                    default: begin
                        regs_d.reload = 1'b1;
                    end
                endcase
            end
        end else if (ctl_wr_i) begin
            if (en_i) regs_d.fault = 1'b0;
            case (action)
                ACT_START: begin
                    regs_d.st           = RS_RUN;
                    regs_d.run          = 1'b1;
                    regs_d.reload       = 1'b1;
                    regs_d.reload_start = 1'b1;
                end
                ACT_RESUME: begin
                    regs_d.st           = RS_RUN;
                    regs_d.run          = 1'b1;
                    regs_d.reload       = 1'b1;
                    regs_d.reload_start = cont_from_start_i;
                    regs_d.clr_cont     = 1'b1;
                end
                ACT_ABANDON: begin
                    regs_d.st = RS_OFF;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{st: RS_OFF, default: 1'b0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign status_o       = regs_q.fault ? STATUS_FAULT : regs_q.st;
    assign run_o          = regs_q.run;
    assign clr_en_o       = regs_q.clr_en;
    assign clr_cont_o     = regs_q.clr_cont;
    assign reload_o       = regs_q.reload;
    assign reload_start_o = regs_q.reload_start;
    assign done_evt_o     = regs_q.done_evt;
    assign pause_evt_o    = regs_q.pause_evt;

    AST_FETCH_ERR_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == 2'd1 && fetch_err_i) |=> (status_o == STATUS_FAULT && !done_evt_o)); // R11

    AST_DONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == 2'd1 && dsc_done_i && !fetch_err_i) |=> done_evt_o); // R7

    AST_REG_MODE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == 2'd1 && dsc_done_i && !fetch_err_i && !mem_mode_i) |=> (status_o == 2'd0 && clr_en_o)); // R3

    AST_START_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == 2'd0 && ctl_wr_i && en_i) |=> (run_o && reload_o && reload_start_o && status_o == 2'd1)); // R8

    AST_RESUME_CLEARS_CONT: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cont_o |-> (run_o && reload_o && status_o == 2'd1)); // R9

    AST_PAUSE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        pause_evt_o |-> (status_o == 2'd2)); // R5

    AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({run_o, clr_en_o, pause_evt_o})); // R2

    AST_IDLE_IGNORES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o != 2'd1 && !ctl_wr_i) |=> $stable(status_o) && !done_evt_o); // R12

endmodule

// File: tb/dma_run_ctl_test.sv
`timescale 1ns/1ps
module dma_run_ctl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0, en = 1'b0, cont = 1'b0, cfs = 1'b0, mem_mode = 1'b0;
    logic       dsc_done = 1'b0, fetch_err = 1'b0;
    logic [1:0] dsc_cmd = 2'd0;
    logic [1:0] status;
    logic       run, clr_en, clr_cont, reload, reload_start, done_evt, pause_evt;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    finished = 1'b0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    dma_run_ctl uut (
        .clk(clk), .rst_n(rst_n), .ctl_wr_i(ctl_wr), .en_i(en), .cont_i(cont),
        .cont_from_start_i(cfs), .mem_mode_i(mem_mode), .dsc_done_i(dsc_done),
        .dsc_cmd_i(dsc_cmd), .fetch_err_i(fetch_err), .status_o(status),
        .run_o(run), .clr_en_o(clr_en), .clr_cont_o(clr_cont), .reload_o(reload),
        .reload_start_o(reload_start), .done_evt_o(done_evt), .pause_evt_o(pause_evt)
    );

    // behavioural reference: state 0 off, 1 running, 2 parked
    int m_st, m_err;
    logic [8:0] m_exp;

    always @(posedge clk or negedge rst_n) begin
        int e_run, e_ce, e_cc, e_rl, e_rs, e_de, e_pe;
        e_run = 0; e_ce = 0; e_cc = 0; e_rl = 0; e_rs = 0; e_de = 0; e_pe = 0;
        if (!rst_n) begin
            m_st = 0; m_err = 0;
        end else if (m_st == 1) begin
            if (fetch_err) begin
                m_st = 0; m_err = 1;
            end else if (dsc_done) begin
                e_de = 1;
                if (!mem_mode || dsc_cmd == 2) begin m_st = 0; e_ce = 1; end
                else if (dsc_cmd == 1) begin m_st = 2; e_pe = 1; end
                else e_rl = 1;
            end
        end else if (ctl_wr) begin
            if (en) m_err = 0;
            if (m_st == 0 && en) begin
                m_st = 1; e_run = 1; e_rl = 1; e_rs = 1;
            end else if (m_st == 2 && cont) begin
                if (en) begin m_st = 1; e_run = 1; e_rl = 1; e_rs = int'(cfs); e_cc = 1; end
                else m_st = 0;
            end
        end
        m_exp = {(m_err != 0) ? 2'd3 : 2'(m_st), 1'(e_run), 1'(e_ce), 1'(e_cc),
                 1'(e_rl), 1'(e_rs), 1'(e_de), 1'(e_pe)};
    end

    function automatic logic [8:0] obs();
        return {status, run, clr_en, clr_cont, reload, reload_start, done_evt, pause_evt};
    endfunction

    always @(negedge clk) begin
        if (!finished) begin
            n_checks++;
            if (obs() !== m_exp) begin
                n_fail++;
                $display("FAIL %s model compare: actual %h expected %h", cur_req, obs(), m_exp);
            end
        end
    end

    // expected vector: status, run, clr_en, clr_cont, reload, reload_start, done, pause
    task automatic check_vec(input string req, input logic [8:0] exp_v);
        n_checks++;
        if (obs() !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, obs(), exp_v);
        end
    endtask

    function automatic logic [8:0] mk(input logic [1:0] st, input logic r, input logic ce,
                                      input logic cc, input logic rl, input logic rs,
                                      input logic de, input logic pe);
        return {st, r, ce, cc, rl, rs, de, pe};
    endfunction

    task automatic ctl_write(input logic e, input logic c, input logic s);
        en = e; cont = c; cfs = s; ctl_wr = 1'b1;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic complete(input logic [1:0] cmd, input logic err);
        dsc_done = 1'b1; dsc_cmd = cmd; fetch_err = err;
        @(negedge clk);
        dsc_done = 1'b0; fetch_err = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
    end

    initial begin
        idle(3);
        check_vec("R1 reset", mk(2'd0, 0, 0, 0, 0, 0, 0, 0));
        rst_n = 1'b1;
        idle(2);
        check_vec("R1 after reset", mk(2'd0, 0, 0, 0, 0, 0, 0, 0));

        cur_req = "R12"; en = 1'b1; idle(3);
        check_vec("R12 enable without strobe", mk(2'd0, 0, 0, 0, 0, 0, 0, 0));

        cur_req = "R8"; mem_mode = 1'b1;
        ctl_write(1, 0, 0);
        check_vec("R8 start", mk(2'd1, 1, 0, 0, 1, 1, 0, 0));

        cur_req = "R6"; complete(2'd0, 0);
        check_vec("R6 cmd0 step", mk(2'd1, 0, 0, 0, 1, 0, 1, 0));
        complete(2'd3, 0);
        check_vec("R6 cmd3 step", mk(2'd1, 0, 0, 0, 1, 0, 1, 0));

        cur_req = "R5"; complete(2'd1, 0);
        check_vec("R5 halt pauses", mk(2'd2, 0, 0, 0, 0, 0, 1, 1));

        cur_req = "R12"; cont = 1'b1; en = 1'b0; idle(2);
        complete(2'd2, 0);
        check_vec("R12 paused ignores completion", mk(2'd2, 0, 0, 0, 0, 0, 0, 0));

        cur_req = "R9"; ctl_write(1, 1, 1);
        check_vec("R9 resume from start", mk(2'd1, 1, 0, 1, 1, 1, 0, 0));
        complete(2'd1, 0);
        ctl_write(1, 1, 0);
        check_vec("R9 resume to next", mk(2'd1, 1, 0, 1, 1, 0, 0, 0));

        cur_req = "R4"; complete(2'd2, 0);
        check_vec("R4 stop disables", mk(2'd0, 0, 1, 0, 0, 0, 1, 0));

        cur_req = "R10"; ctl_write(1, 0, 0);
        complete(2'd1, 0);
        ctl_write(1, 0, 0);
        check_vec("R9 paused without continue stays", mk(2'd2, 0, 0, 0, 0, 0, 0, 0));
        ctl_write(0, 1, 0);
        check_vec("R10 abandon pause", mk(2'd0, 0, 0, 0, 0, 0, 0, 0));

        cur_req = "R3"; mem_mode = 1'b0;
        ctl_write(1, 0, 0);
        complete(2'd1, 0);
        check_vec("R3 register mode ends", mk(2'd0, 0, 1, 0, 0, 0, 1, 0));
        ctl_write(1, 0, 0);
        complete(2'd0, 0);
        check_vec("R3 register mode cmd0 ends", mk(2'd0, 0, 1, 0, 0, 0, 1, 0));

        cur_req = "R11"; mem_mode = 1'b1;
        ctl_write(1, 0, 0);
        complete(2'd0, 1);
        check_vec("R11 fetch error", mk(2'd3, 0, 0, 0, 0, 0, 0, 0));
        fetch_err = 1'b1; idle(2); fetch_err = 1'b0;
        ctl_write(0, 1, 0);
        check_vec("R11 error survives enable=0 write", mk(2'd3, 0, 0, 0, 0, 0, 0, 0));

        cur_req = "R8"; ctl_write(1, 0, 0);
        check_vec("R8 enable clears error", mk(2'd1, 1, 0, 0, 1, 1, 0, 0));
        cur_req = "R2"; idle(2);
        check_vec("R2 running status", mk(2'd1, 0, 0, 0, 0, 0, 0, 0));

        idle(2);
        summary();
    end
endmodule